// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Processor Bus Port

This block is the digital control for a 10-bit successive-approximation converter. A processor sees it as a memory-mapped peripheral. It selects the block with an active-low chip select. A write strobe starts a conversion, and a read strobe fetches the result. The analog parts sit outside the block: a capacitor DAC that takes the trial code, and a comparator that returns one bit, which is high when the trial code is above the sampled input.

A rising write strobe with chip select low puts the sample/hold into hold. The block then tests one bit per conversion-clock period, starting from the MSB. When the last bit is decided, the result moves into an output latch and the active-low end-of-conversion flag drops. A processor can take that flag as an interrupt or poll it. A falling read strobe, with chip select low, raises the flag again, so the read itself acknowledges the interrupt. The data bus is shown as a value plus an output enable, and the pad ring makes it tri-state from these.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After a synchronous reset the block is in track mode (`hold` = 0) with `eoc_n` = 1, `trial_code` = 0, the latch cleared (a read returns 0) and the bus released (`data_oe` = 0, `data_o` = 0).
- R2: `wr_n` and `rd_n` edges have no effect while `cs_n` is high: no conversion starts and `eoc_n` keeps its value.
- R3: Inputs are sampled on each rising `clk` edge. At an edge where `cs_n` is sampled low, `wr_n` is sampled high and `wr_n` was sampled low at the previous edge, the next edge starts a conversion and `hold` goes to 1.
- R4: A conversion takes `WIDTH`*`CONV_DIV` cycles (20 by default) with `hold` = 1. The first trial code is the MSB alone (10'h200). One bit is decided every `CONV_DIV` cycles, MSB to LSB. A bit is kept unless `cmp_gt` = 1 reports that the trial code exceeds the input. `hold` then returns to 0 (track mode).
- R5: With an ideal comparator the result is the input code clamped to the range. An input at or above 1023 gives all ones and an input at or below 0 gives all zeros. Bit 0 of the result is the LSB and bit 9 is the MSB.
- R6: One cycle after the last bit decision, `eoc_n` falls and the output latch loads the result at that same edge.
- R7: `data_oe` is 1 and `data_o` shows the latch exactly while `cs_n` and `rd_n` are both low. Otherwise `data_oe` = 0 and `data_o` = 0.
- R8: At an edge where `cs_n` is sampled low, `rd_n` is sampled low and `rd_n` was sampled high at the previous edge, the next edge sets `eoc_n` to 1. A result being loaded in that cycle takes priority and keeps the flag low.
- R9: A write strobe during a conversion is ignored. The conversion keeps its length and its result.
- R10: The latch changes only when `eoc_n` falls. While a later conversion is running, reads still return the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; its rising edge starts a conversion |
| rd_n | input | 1 | Active-low read strobe; its falling edge clears the flag |
| cmp_gt | input | 1 | Comparator: 1 when the trial code exceeds the held input |
| trial_code | output | 10 | Code presented to the DAC during the bit trials |
| hold | output | 1 | Sample/hold control: 1 = hold, 0 = track |
| eoc_n | output | 1 | Active-low end-of-conversion flag |
| data_o | output | 10 | Result value for the bus pads, zero when not driven |
| data_oe | output | 1 | Output enable for the bus pads |

## Verification
The assertions assume that the strobes and chip select are already synchronous to `clk`. They also assume that `cmp_gt` answers the trial code in the same cycle, and that the analog input is stable for the whole hold period. The bench drives every strobe and select on the falling clock edge and holds each level for at least one full cycle. It changes the input code only while `hold` is 0 and computes `cmp_gt` combinationally from `trial_code`. That keeps the stimulus inside these assumptions.

// File: rtl/sar_pkg.sv
// Shared types for the converter sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_pkg;
    typedef enum logic {
        ST_TRACK   = 1'b0,
        ST_CONVERT = 1'b1
    } sar_state_e;
endpackage

// File: rtl/sar_strobe_edge.sv
// Turns the chip-select-qualified write and read strobes into one-cycle
// request pulses: start on a rising write strobe, acknowledge on a falling
// read strobe.
// Assumes: the strobes are already synchronous to clk.
module sar_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic start_req,
    output logic read_req
);
    logic cs_q, wr_q, wr_qq, rd_q, rd_qq;

    // Purpose: keep the current and the previous sample of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            wr_q  <= 1'b1;
            wr_qq <= 1'b1;
            rd_q  <= 1'b1;
            rd_qq <= 1'b1;
        end else begin
            cs_q  <= cs_n;
            wr_q  <= wr_n;
            wr_qq <= wr_q;
            rd_q  <= rd_n;
            rd_qq <= rd_q;
        end
    end

    // Purpose: detect the edges, qualified by chip select in the same sample.
    always_comb begin
        start_req = !cs_q && wr_q && !wr_qq;
        read_req  = !cs_q && !rd_q && rd_qq;
    end
endmodule

// File: rtl/sar_engine.sv
// Bit-trial engine: holds the input, tests one bit every CONV_DIV cycles
// from MSB to LSB, and pulses done together with the final code.
// Assumes: cmp_gt answers the current trial_code in the same cycle.
module sar_engine
    import sar_pkg::*;
#(
    parameter int WIDTH    = 10,
    parameter int CONV_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cmp_gt,
    output logic [WIDTH-1:0] trial_code,
    output logic             hold,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int CNT_W = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
    localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    sar_state_e       state;
    logic [IDX_W-1:0] bit_idx;
    logic [CNT_W-1:0] div_cnt;
    logic [WIDTH-1:0] trial;
    logic [WIDTH-1:0] cur_mask, low_mask, decided;
    logic             tick;

    // Purpose: form the current bit mask and the decision for that bit.
    always_comb begin
        cur_mask = WIDTH'(1) << bit_idx;
        low_mask = cur_mask | (cur_mask - WIDTH'(1));
        decided  = cmp_gt ? (trial & ~cur_mask) : trial;
        tick     = (div_cnt == CNT_W'(CONV_DIV - 1));
    end

    // Purpose: sequence the conversion and register the final code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_TRACK;
            bit_idx <= '0;
            div_cnt <= '0;
            trial   <= '0;
            result  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_TRACK: begin
                    if (start_req) begin
                        state   <= ST_CONVERT;
                        trial   <= MSB_ONE;
                        bit_idx <= IDX_W'(WIDTH - 1);
                        div_cnt <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        div_cnt <= '0;
                        if (bit_idx == '0) begin
                            state  <= ST_TRACK;
                            result <= decided;
                            done   <= 1'b1;
                            trial  <= '0;
                        end else begin
                            trial   <= decided | (cur_mask >> 1);
                            bit_idx <= bit_idx - IDX_W'(1);
                        end
                    end else begin
                        div_cnt <= div_cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign trial_code = trial;
    assign hold       = (state == ST_CONVERT);

    // R3: a start request in track mode puts the input into hold
    a_r3_start_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && start_req) |=> hold);

    // R4: the bit under trial is set and every lower bit is still clear
    a_r4_trial_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ((trial_code & low_mask) == cur_mask));

    // R4: leaving hold always coincides with a finished code
    a_r4_hold_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> done);

    // R9: nothing aborts or restarts a conversion before its last decision
    a_r9_conv_not_aborted: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !(tick && bit_idx == '0)) |=> (hold && !done));
endmodule

// File: rtl/sar_result_latch.sv
// Output latch, end-of-conversion flag and bus drive.
// Assumes: done is a one-cycle pulse carrying a valid result.
module sar_result_latch #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [WIDTH-1:0] result,
    input  logic             read_req,
    input  logic             cs_n,
    input  logic             rd_n,
    output logic             eoc_n,
    output logic [WIDTH-1:0] data_o,
    output logic             data_oe
);
    logic [WIDTH-1:0] latch_q;

    // Purpose: load the result as the flag falls; a read acknowledge raises it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            eoc_n   <= 1'b1;
        end else if (done) begin
            latch_q <= result;
            eoc_n   <= 1'b0;
        end else if (read_req) begin
            eoc_n   <= 1'b1;
        end
    end

    // Purpose: drive the bus only during a selected read.
    always_comb begin
        data_oe = !cs_n && !rd_n;
        data_o  = data_oe ? latch_q : '0;
    end

    // R6: the flag only falls right after a finished conversion
    a_r6_eoc_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> $past(done));

    // R10: the latch keeps its value unless a result is being loaded
    a_r10_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(latch_q));

    // R8: a read acknowledge without a competing result releases the flag
    a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (read_req && !done) |=> eoc_n);

    // R8: a result arriving together with a read keeps the flag low
    a_r8_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !eoc_n);
endmodule

// File: rtl/sar_bus_ctrl.sv
// Top of the converter sequencer: strobe edge detection, bit-trial engine
// and result latch with bus drive.
// Assumes: strobes synchronous to clk; the pad ring forms the tri-state bus
// from data_o and data_oe.
module sar_bus_ctrl #(
    parameter int WIDTH    = 10,
    parameter int CONV_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cmp_gt,
    output logic [WIDTH-1:0] trial_code,
    output logic             hold,
    output logic             eoc_n,
    output logic [WIDTH-1:0] data_o,
    output logic             data_oe
);
    logic             start_req, read_req, done;
    logic [WIDTH-1:0] result;

    sar_strobe_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .start_req (start_req),
        .read_req  (read_req)
    );

    sar_engine #(.WIDTH(WIDTH), .CONV_DIV(CONV_DIV)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .cmp_gt     (cmp_gt),
        .trial_code (trial_code),
        .hold       (hold),
        .done       (done),
        .result     (result)
    );

    sar_result_latch #(.WIDTH(WIDTH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .result   (result),
        .read_req (read_req),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .eoc_n    (eoc_n),
        .data_o   (data_o),
        .data_oe  (data_oe)
    );

    // R2: with chip select held high for two samples, no new conversion starts
    a_r2_cs_gates_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n && !hold) |=> !hold);
endmodule

// File: tb/sar_bus_ctrl_tb.sv
// Bench for sar_bus_ctrl: a behavioural reference model updated on each
// rising edge and compared with the outputs on each falling edge, plus
// directed scenario checks.
module sar_bus_ctrl_tb;
    localparam int W    = 10;
    localparam int DIV  = 2;
    localparam int CONV = W * DIV;
    localparam int FULL = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic         cmp_gt;
    logic [W-1:0] trial_code, data_o;
    logic         hold, eoc_n, data_oe;
    int           vin = 0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    assign cmp_gt = (int'(trial_code) > vin);

    sar_bus_ctrl #(.WIDTH(W), .CONV_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_gt(cmp_gt), .trial_code(trial_code), .hold(hold),
        .eoc_n(eoc_n), .data_o(data_o), .data_oe(data_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clamp_code(input int v);
        if (v < 0) return 0;
        if (v > FULL) return FULL;
        return v;
    endfunction

    // Reference model state (behavioural, integers only)
    int m_cs1, m_wr1, m_wr2, m_rd1, m_rd2;
    int m_left, m_res, m_latch;
    bit m_busy, m_done, m_eoc_n;

    always @(posedge clk) begin
        bit rise, fall;
        if (!rst_n) begin
            m_cs1 = 1; m_wr1 = 1; m_wr2 = 1; m_rd1 = 1; m_rd2 = 1;
            m_left = 0; m_res = 0; m_latch = 0;
            m_busy = 0; m_done = 0; m_eoc_n = 1;
        end else begin
            rise = (m_cs1 == 0) && (m_wr1 == 1) && (m_wr2 == 0);
            fall = (m_cs1 == 0) && (m_rd1 == 0) && (m_rd2 == 1);
            if (m_done) begin
                m_latch = m_res; m_eoc_n = 0; m_done = 0;
            end else if (fall) begin
                m_eoc_n = 1;
            end
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_res = clamp_code(vin);
                end
            end else if (rise) begin
                m_busy = 1; m_left = CONV;
            end
            m_cs1 = cs_n; m_wr2 = m_wr1; m_wr1 = wr_n; m_rd2 = m_rd1; m_rd1 = rd_n;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(hold == m_busy, "R4 hold", hold, m_busy);
            check(eoc_n == m_eoc_n, "R6 eoc_n", eoc_n, m_eoc_n);
            check(data_oe == (!cs_n && !rd_n), "R7 data_oe", data_oe, !cs_n && !rd_n);
            check(int'(data_o) == ((!cs_n && !rd_n) ? m_latch : 0), "R7 data_o",
                  data_o, (!cs_n && !rd_n) ? m_latch : 0);
        end
    end

    // Length of the most recent hold period
    int run_len = 0, last_run = 0;
    always @(negedge clk) begin
        if (hold) run_len++;
        else if (run_len > 0) begin last_run = run_len; run_len = 0; end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input bit sel);
        @(negedge clk); cs_n = !sel; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic do_read(input bit sel, output int val);
        @(negedge clk); cs_n = !sel; rd_n = 1'b0;
        @(negedge clk); val = int'(data_o);
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic wait_eoc;
        for (int i = 0; i < 200 && eoc_n; i++) @(negedge clk);
    endtask

    task automatic convert_and_read(input int v, input string req);
        int got;
        vin = v;
        do_write(1'b1);
        wait_eoc();
        cycles(1);
        do_read(1'b1, got);
        check(got == clamp_code(v), req, got, clamp_code(v));
        cycles(2);
        check(eoc_n == 1'b1, "R8 flag released by read", eoc_n, 1);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stimulus
        int got;
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        // R1: reset state
        check(hold == 1'b0, "R1 hold after reset", hold, 0);
        check(eoc_n == 1'b1, "R1 eoc_n after reset", eoc_n, 1);
        check(data_oe == 1'b0, "R1 bus released", data_oe, 0);
        check(trial_code == '0, "R1 trial_code", trial_code, 0);
        do_read(1'b1, got);
        check(got == 0, "R1 latch cleared", got, 0);

        // R3 / R4: start, MSB first trial, conversion length
        vin = 517;
        do_write(1'b1);
        for (int i = 0; i < 10 && !hold; i++) @(negedge clk);
        check(hold == 1'b1, "R3 hold after write", hold, 1);
        check(trial_code == 10'h200, "R4 first trial is MSB", trial_code, 'h200);
        wait_eoc();
        check(last_run == CONV, "R4 conversion length", last_run, CONV);
        check(hold == 1'b0, "R4 back to track", hold, 0);
        cycles(1);
        do_read(1'b1, got);
        check(got == 517, "R5 mid-scale code", got, 517);
        cycles(2);
        check(eoc_n == 1'b1, "R8 read clears flag", eoc_n, 1);

        // R5: range ends and bit order
        convert_and_read(2000, "R5 above top gives all ones");
        convert_and_read(FULL, "R5 top code");
        convert_and_read(-5, "R5 below bottom gives zeros");
        convert_and_read(0, "R5 bottom code");
        convert_and_read(1, "R5 LSB is bit 0");
        convert_and_read(512, "R5 MSB is bit 9");

        // R2: write strobe with chip select high
        vin = 100;
        do_write(1'b0);
        cycles(4);
        check(hold == 1'b0, "R2 write ignored without select", hold, 0);

        // R2: read strobe with chip select high leaves the flag low
        vin = 300;
        do_write(1'b1);
        wait_eoc();
        do_read(1'b0, got);
        cycles(2);
        check(eoc_n == 1'b0, "R2 read ignored without select", eoc_n, 0);
        check(got == 0, "R2 bus not driven without select", got, 0);

        // R10: old result readable during the next conversion
        vin = 700;
        do_write(1'b1);
        cycles(3);
        do_read(1'b1, got);
        check(got == 300, "R10 previous result kept", got, 300);

        // R9: second write during this conversion is ignored
        do_write(1'b1);
        wait_eoc();
        check(last_run == CONV, "R9 length unchanged", last_run, CONV);
        cycles(1);
        do_read(1'b1, got);
        check(got == 700, "R9 result unchanged", got, 700);
        cycles(3);
        check(hold == 1'b0, "R9 no extra conversion", hold, 0);

        cycles(5);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule